// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the status byte of a small 8-bit microcontroller core. Each cycle it takes the ALU operands, the carry-in, the result the datapath produced, and an operation class. From these it derives the carry, half-carry, zero and overflow flags and registers them. It also keeps two sticky power-management bits, power-down and watchdog time-out. Only system event strobes move these two bits: power-up, clear-watchdog, halt and watchdog time-out.

Software may load the four arithmetic flags through a write port. The registered byte is always visible on the `status` output. The ALU datapath, the watchdog counter and the instruction decoder sit outside the block. The block sees only their results and strobes.

Top module: `status_flag_reg`

## Requirements
- R1: With `op_class` = 1 (add), bit 0 (carry) takes the carry out of `opnd_a + opnd_b + carry_in`.
- R2: With `op_class` = 2 (subtract), the block forms `opnd_a + ~opnd_b + carry_in`. Bit 0 is 1 when no borrow occurs (the sum carries out) and 0 otherwise. A `carry_in` of 1 means no incoming borrow.
- R3: For add and subtract, bit 1 (half carry) is the carry out of the low 4-bit sum, with the same operand inversion for subtract.
- R4: For add, subtract and logic (`op_class` = 4), bit 2 (zero) is 1 exactly when `alu_result` is zero.
- R5: For add and subtract, bit 3 (overflow) is the carry into bit 7 XOR the carry out of bit 7.
- R6: With `op_class` = 3 (rotate through carry), bit 0 takes `opnd_a[7]` when `rot_left` is 1 and `opnd_a[0]` otherwise. Bits 1 to 3 keep their values.
- R7: A logic operation changes only bit 2. Class 0 and the unused codes 5 to 7 leave bits 0 to 3 unchanged.
- R8: When `wr_en` is 1, bits 0 to 3 load `wr_data[3:0]` on the next edge, and this overrides any ALU update in that cycle. Bits 4 and 5 ignore the write.
- R9: Bit 4 (power-down) is set by `halt` and cleared by `pwr_up` or `clr_wdt`. A clear wins over a set in the same cycle.
- R10: Bit 5 (time-out) is set by `wdt_to` and cleared by `pwr_up`, `clr_wdt` or `halt`. A clear wins over a set in the same cycle.
- R11: Bits 6 and 7 always read 0. After reset the whole byte is 0.
- R12: An event strobe and an ALU flag update in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 3 | Operation class: 0 none, 1 add, 2 subtract, 3 rotate, 4 logic |
| opnd_a | input | 8 | First ALU operand |
| opnd_b | input | 8 | Second ALU operand |
| carry_in | input | 1 | Carry (no-borrow) into the add/subtract |
| alu_result | input | 8 | Result from the datapath |
| rot_left | input | 1 | Rotate direction: 1 left, 0 right |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write data |
| pwr_up | input | 1 | Power-up event |
| clr_wdt | input | 1 | Clear-watchdog event |
| halt | input | 1 | Halt event |
| wdt_to | input | 1 | Watchdog time-out event |
| status | output | 8 | Registered status byte |

## Verification
The assertions assume that `alu_result` matches the operation the class names, because the zero flag comes straight from that input. They also assume that the operands are stable in the cycle they are sampled. The random stimulus meets the first assumption by computing each result from the drawn operands and class before driving it, and meets the second by holding all inputs for one full cycle. Event strobes are drawn rarely and independently, so same-cycle combinations of events with each other and with ALU updates all occur.

// File: rtl/status_pkg.sv
package status_pkg;
   typedef enum logic [2:0] {
      OPC_NONE  = 3'd0,
      OPC_ADD   = 3'd1,
      OPC_SUB   = 3'd2,
      OPC_ROTC  = 3'd3,
      OPC_LOGIC = 3'd4
   } op_class_e;

   typedef struct packed {
      logic ov;
      logic z;
      logic ac;
      logic c;
   } arith_flags_t;

   localparam int ARITH_BITS = 4;
   localparam int PDN_POS    = 4;
   localparam int TMO_POS    = 5;
endpackage

// File: rtl/flag_calc.sv
module flag_calc #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [2:0]                  op_class,
   input  logic [DATA_W-1:0]           opnd_a,
   input  logic [DATA_W-1:0]           opnd_b,
   input  logic                        carry_in,
   input  logic [DATA_W-1:0]           alu_result,
   input  logic                        rot_left,
   input  status_pkg::arith_flags_t    cur,
   output status_pkg::arith_flags_t    nxt
);
   import status_pkg::*;

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W too small");
      assert (NIB_W >= 1 && NIB_W < DATA_W) else $error("NIB_W out of range");
   end

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   full_sum;
   logic [NIB_W:0]    nib_sum;
   logic [DATA_W-1:0] below_msb;
   logic              res_zero;

   always_comb begin
      b_eff     = (op_class == OPC_SUB) ? ~opnd_b : opnd_b;
      full_sum  = {1'b0, opnd_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, carry_in};
      nib_sum   = {1'b0, opnd_a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                + {{NIB_W{1'b0}}, carry_in};
      below_msb = {1'b0, opnd_a[DATA_W-2:0]} + {1'b0, b_eff[DATA_W-2:0]}
                + {{(DATA_W-1){1'b0}}, carry_in};
      res_zero  = (alu_result == '0);
   end

   always_comb begin
      nxt = cur;
      case (op_class)
         OPC_ADD, OPC_SUB: begin
            nxt.c  = full_sum[DATA_W];
            nxt.ac = nib_sum[NIB_W];
            nxt.z  = res_zero;
            nxt.ov = below_msb[DATA_W-1] ^ full_sum[DATA_W];
         end
         OPC_ROTC:  nxt.c = rot_left ? opnd_a[DATA_W-1] : opnd_a[0];
         OPC_LOGIC: nxt.z = res_zero;
         default:   nxt = cur;
      endcase
   end

   always_comb begin
      if (op_class == OPC_ROTC)
         a_r6_rot_keeps: assert ({nxt.ov, nxt.z, nxt.ac} == {cur.ov, cur.z, cur.ac});
      if (op_class == OPC_LOGIC)
         a_r7_logic_only_z: assert ({nxt.ov, nxt.ac, nxt.c} == {cur.ov, cur.ac, cur.c});
   end
endmodule

// File: rtl/power_flags.sv
module power_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_up,
   input  logic clr_wdt,
   input  logic halt,
   input  logic wdt_to,
   output logic pdn,
   output logic tmo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pdn <= 1'b0;
         tmo <= 1'b0;
      end else begin
         if (pwr_up || clr_wdt)        pdn <= 1'b0;
         else if (halt)                pdn <= 1'b1;
         if (pwr_up || clr_wdt || halt) tmo <= 1'b0;
         else if (wdt_to)               tmo <= 1'b1;
      end
   end

   a_r9_halt_sets_pdn: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !pwr_up && !clr_wdt) |=> pdn);
   a_r9_clear_pdn: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_up || clr_wdt) |=> !pdn);
   a_r10_wdt_sets_tmo: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_to && !pwr_up && !clr_wdt && !halt) |=> tmo);
   a_r10_clear_tmo: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_up || clr_wdt || halt) |=> !tmo);
   a_r9_pdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_up && !clr_wdt && !halt) |=> $stable(pdn));
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg #(
   parameter int DATA_W   = 8,
   parameter int NIB_W    = 4,
   parameter int STATUS_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          op_class,
   input  logic [DATA_W-1:0]   opnd_a,
   input  logic [DATA_W-1:0]   opnd_b,
   input  logic                carry_in,
   input  logic [DATA_W-1:0]   alu_result,
   input  logic                rot_left,
   input  logic                wr_en,
   input  logic [STATUS_W-1:0] wr_data,
   input  logic                pwr_up,
   input  logic                clr_wdt,
   input  logic                halt,
   input  logic                wdt_to,
   output logic [STATUS_W-1:0] status
);
   import status_pkg::*;

   localparam int USED_BITS = TMO_POS + 1;

   initial begin
      assert (STATUS_W >= USED_BITS) else $error("STATUS_W too small");
   end

   arith_flags_t flags_q, flags_calc;
   logic         pdn, tmo;

   flag_calc #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_calc (
      .op_class   (op_class),
      .opnd_a     (opnd_a),
      .opnd_b     (opnd_b),
      .carry_in   (carry_in),
      .alu_result (alu_result),
      .rot_left   (rot_left),
      .cur        (flags_q),
      .nxt        (flags_calc)
   );

   power_flags u_pwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_up  (pwr_up),
      .clr_wdt (clr_wdt),
      .halt    (halt),
      .wdt_to  (wdt_to),
      .pdn     (pdn),
      .tmo     (tmo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flags_q <= '0;
      else if (wr_en) flags_q <= arith_flags_t'(wr_data[ARITH_BITS-1:0]);
      else            flags_q <= flags_calc;
   end

   assign status[ARITH_BITS-1:0] = flags_q;
   assign status[PDN_POS]        = pdn;
   assign status[TMO_POS]        = tmo;

   generate
      for (genvar gi = USED_BITS; gi < STATUS_W; gi++) begin : g_pad
         assign status[gi] = 1'b0;
      end
   endgenerate

   a_r11_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status[STATUS_W-1:USED_BITS] == '0);
   a_r7_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && (op_class == 3'd0 || op_class > 3'd4)) |=> $stable(status[3:0]));
   a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> status[3:0] == $past(wr_data[3:0]));
   a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && (op_class == 3'd1 || op_class == 3'd2 || op_class == 3'd4))
      |=> status[2] == ($past(alu_result) == '0));
   a_r10_write_ignores_tmo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pwr_up && !clr_wdt && !halt && !wdt_to) |=> $stable(status[5:4]));
endmodule

// File: tb/tb_status_flag_reg.sv
module tb_status_flag_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_class = '0;
   logic [7:0] opnd_a = '0, opnd_b = '0, alu_result = '0, wr_data = '0;
   logic       carry_in = 0, rot_left = 0, wr_en = 0;
   logic       pwr_up = 0, clr_wdt = 0, halt = 0, wdt_to = 0;
   logic [7:0] status;

   int errors = 0;
   int checks = 0;
   logic [3:0] exp_ar = '0;
   logic       exp_pdn = 0, exp_tmo = 0;

   always #2.5 clk = ~clk;

   status_flag_reg dut (.*);

   initial begin
      #900000;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   function automatic logic [3:0] model_arith(input logic [3:0] cur, input logic [2:0] op,
         input logic [7:0] a, input logic [7:0] b, input logic ci, input logic [7:0] res,
         input logic rl, input logic we, input logic [7:0] wd);
      logic [7:0] bb; logic [8:0] s; logic [4:0] lo; logic [7:0] m7;
      if (we) return wd[3:0];
      bb = (op == 3'd2) ? ~b : b;
      s  = {1'b0, a} + {1'b0, bb} + {8'd0, ci};
      lo = {1'b0, a[3:0]} + {1'b0, bb[3:0]} + {4'd0, ci};
      m7 = {1'b0, a[6:0]} + {1'b0, bb[6:0]} + {7'd0, ci};
      case (op)
         3'd1, 3'd2: return {m7[7] ^ s[8], res == 8'd0, lo[4], s[8]};
         3'd3:       return {cur[3:1], rl ? a[7] : a[0]};
         3'd4:       return {cur[3], res == 8'd0, cur[1:0]};
         default:    return cur;
      endcase
   endfunction

   function automatic logic [7:0] model_result(input logic [2:0] op, input logic [7:0] a,
         input logic [7:0] b, input logic ci, input logic rl, input logic c_now);
      logic [7:0] bb;
      bb = (op == 3'd2) ? ~b : b;
      case (op)
         3'd1, 3'd2: return a + bb + {7'd0, ci};
         3'd3:       return rl ? {a[6:0], c_now} : {c_now, a[7:1]};
         3'd4:       return a & b;
         default:    return a ^ b;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic check_all(input string c_tag, input string ov_tag);
      chk(c_tag, {7'd0, status[0]}, {7'd0, exp_ar[0]});
      chk(ov_tag.len() > 0 ? ov_tag : "R3", {7'd0, status[1]}, {7'd0, exp_ar[1]});
      chk(ov_tag.len() > 0 ? ov_tag : "R4", {7'd0, status[2]}, {7'd0, exp_ar[2]});
      chk(ov_tag.len() > 0 ? ov_tag : "R5", {7'd0, status[3]}, {7'd0, exp_ar[3]});
      chk(ov_tag.len() > 0 ? ov_tag : "R9", {7'd0, status[4]}, {7'd0, exp_pdn});
      chk(ov_tag.len() > 0 ? ov_tag : "R10", {7'd0, status[5]}, {7'd0, exp_tmo});
      chk("R11", {6'd0, status[7:6]}, 8'd0);
   endtask

   task automatic step(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
         input logic ci, input logic rl, input logic we, input logic [7:0] wd,
         input logic [3:0] ev, input logic force_res, input logic [7:0] fres,
         input string tag);
      logic [7:0] res;
      string ctag;
      res = force_res ? fres : model_result(op, a, b, ci, rl, exp_ar[0]);
      op_class = op; opnd_a = a; opnd_b = b; carry_in = ci; rot_left = rl;
      alu_result = res; wr_en = we; wr_data = wd;
      {pwr_up, clr_wdt, halt, wdt_to} = ev;
      exp_ar = model_arith(exp_ar, op, a, b, ci, res, rl, we, wd);
      if (ev[3] || ev[2])     exp_pdn = 1'b0;
      else if (ev[1])         exp_pdn = 1'b1;
      if (ev[3] || ev[2] || ev[1]) exp_tmo = 1'b0;
      else if (ev[0])         exp_tmo = 1'b1;
      if (we)               ctag = "R8";
      else if (op == 3'd1)  ctag = "R1";
      else if (op == 3'd2)  ctag = "R2";
      else if (op == 3'd3)  ctag = "R6";
      else                  ctag = "R7";
      @(posedge clk);
      @(negedge clk);
      check_all(tag.len() > 0 ? tag : ctag, tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      @(negedge clk);
      check_all("R11", "R11");
      rst_n = 1'b1;

      // directed corners
      step(3'd1, 8'hFF, 8'h01, 1'b0, 0, 0, 0, 4'b0000, 0, 0, "R1");   // carry, zero, half
      step(3'd1, 8'h7F, 8'h01, 1'b0, 0, 0, 0, 4'b0000, 0, 0, "R5");   // signed overflow
      step(3'd2, 8'h05, 8'h05, 1'b1, 0, 0, 0, 4'b0000, 0, 0, "R2");   // no borrow, zero
      step(3'd2, 8'h10, 8'h01, 1'b1, 0, 0, 0, 4'b0000, 0, 0, "R3");   // nibble borrow
      step(3'd2, 8'h80, 8'h01, 1'b1, 0, 0, 0, 4'b0000, 0, 0, "R5");   // overflow on sub
      step(3'd3, 8'h81, 8'h00, 1'b0, 1, 0, 0, 4'b0000, 0, 0, "R6");
      step(3'd4, 8'hF0, 8'h0F, 1'b0, 0, 0, 0, 4'b0000, 0, 0, "R7");
      step(3'd1, 8'h01, 8'h01, 1'b0, 0, 1, 8'hFA, 4'b0000, 0, 0, "R8");
      step(3'd0, 8'h00, 8'h00, 1'b0, 0, 0, 0, 4'b0010, 0, 0, "R9");
      step(3'd0, 8'h00, 8'h00, 1'b0, 0, 0, 0, 4'b0001, 0, 0, "R10");
      step(3'd0, 8'h00, 8'h00, 1'b0, 0, 1, 8'hFF, 4'b0000, 0, 0, "R8");
      step(3'd1, 8'hFF, 8'hFF, 1'b1, 0, 0, 0, 4'b0110, 0, 0, "R12");  // clear wins, ALU too
      step(3'd4, 8'h00, 8'h00, 1'b0, 0, 0, 0, 4'b1011, 0, 0, "R12");
      step(3'd6, 8'h12, 8'h34, 1'b1, 0, 0, 0, 4'b0000, 0, 0, "R7");

      for (int i = 0; i < 3000; i++) begin
         logic [3:0] ev;
         ev = 4'b0000;
         for (int k = 0; k < 4; k++) ev[k] = ($urandom_range(0, 9) == 0);
         step(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 1'($urandom),
              1'($urandom), ($urandom_range(0, 7) == 0), 8'($urandom), ev, 0, 0, "");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule